// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

This block turns single read requests from inside the chip into read cycles on an external asynchronous memory that supports page mode. For each accepted request it drives the word-aligned address, the active-low chip select and the active-low output enable. It counts out a programmed number of clock cycles and then captures the memory's data bus into a one-cycle response.

Page memories answer the first read of a page slowly and later reads in the same page quickly. The sequencer keeps the page address of the last read in a page register. A read whose page matches the open page runs for the short in-page cycle count, and any other read runs for the long first-access count. The page size is 4, 8, 16 or 32 bytes, and each page is aligned to its own size. With page mode off, every read runs for the long count.

Chip select stays low across back-to-back reads. It goes high for one cycle before a read that opens a new page. It also goes high when no request follows a response, and that closes the page.

Top module: `pgrd_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, mem_cs_n and mem_oe_n are 1, req_ready is 1 and rsp_valid is 0.
- R2: A read accepted while chip select is high opens a page and runs for cfg_first_cyc+1 cycles. rsp_valid is high exactly that many clock edges after the edge that accepted the request.
- R3: With page mode on, a read accepted on the cycle right after a response, whose page address matches the open page, keeps chip select low. Its response comes cfg_inpage_cyc+1 edges after acceptance.
- R4: cfg_page_sel values 0, 1, 2 and 3 select page sizes of 4, 8, 16 and 32 bytes. The page address is req_addr[ADDR_W-1:2+cfg_page_sel]. Address bits below that position do not affect the page match, and a difference at bit 2+cfg_page_sel is a page miss.
- R5: A back-to-back read that misses the open page raises mem_cs_n for exactly one cycle. It then runs for the long count, so its response comes cfg_first_cyc+2 edges after acceptance.
- R6: With cfg_page_en at 0, every read uses the long count, including a back-to-back read to the same page.
- R7: If req_valid is low on the cycle after a response, chip select is released and the page closes. The next read runs for the long count without a gap cycle.
- R8: A change of cfg_page_sel closes the open page. A back-to-back read on the cycle of the change is treated as a miss.
- R9: req_ready is 0 from the acceptance edge until the response, and each accepted request yields exactly one rsp_valid pulse.
- R10: mem_addr carries the accepted address with the bits below the bus width forced to 0. With BUS_BYTES of 4 these are bits [1:0], with 2 only bit 0, and with 1 none.
- R11: rsp_data equals the value of mem_din on the last cycle that mem_oe_n is low. mem_addr does not change while mem_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page_en | input | 1 | 1 enables page-mode timing |
| cfg_page_sel | input | 2 | Page size select: 0=4, 1=8, 2=16, 3=32 bytes |
| cfg_first_cyc | input | CNT_W | Long access length minus one |
| cfg_inpage_cyc | input | CNT_W | In-page access length minus one |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle pulse, read data valid |
| rsp_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | External address bus |
| mem_cs_n | output | 1 | External chip select, active low |
| mem_oe_n | output | 1 | External read strobe, active low |
| mem_din | input | DATA_W | External read data bus |

## Verification
The assertions assume three things about the inputs. Configuration changes only while no access is in progress. The memory's data bus depends only on the address it is given. Reset is applied before the first request. The bench changes configuration only at a falling edge while the block is idle or holding a page, except in the page-size-change scenario, which changes it on purpose on the back-to-back cycle. The memory model is a pure function of mem_addr, so captured data can be predicted from the request address. Latency, gap cycles and ready are measured at falling edges by counting clock edges from acceptance.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_GAP  = 2'd2,
      ST_ACC  = 2'd3
   } pgrd_state_e;
endpackage

// File: rtl/pgrd_timer.sv
module pgrd_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   if (CNT_W < 1) begin : g_bad_w
      $error("pgrd_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (run && cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = run && (cnt == '0);

   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pgrd_page_track.sv
module pgrd_page_track #(
   parameter int ADDR_W = 26,
   parameter int SEL_W  = 2,
   parameter int MIN_LG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_en,
   input  logic [SEL_W-1:0]  page_sel,
   input  logic [ADDR_W-1:0] probe_addr,
   input  logic              open_page,
   input  logic              close_page,
   output logic              hit
);
   localparam int NSIZE = 1 << SEL_W;

   logic [ADDR_W-1:0] mask_tab [NSIZE];
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] tag;
   logic [SEL_W-1:0]  sel_q;
   logic              valid;

   if (ADDR_W <= MIN_LG + NSIZE - 1) begin : g_bad_w
      $error("pgrd_page_track: ADDR_W too small for largest page");
   end

   for (genvar i = 0; i < NSIZE; i++) begin : g_mask
      assign mask_tab[i] = {ADDR_W{1'b1}} << (MIN_LG + i);
   end

   assign mask = mask_tab[page_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         tag   <= '0;
         sel_q <= '0;
      end else begin
         sel_q <= page_sel;
         if (open_page) tag <= probe_addr & mask;
         if (!page_en || page_sel != sel_q || close_page) valid <= 1'b0;
         else if (open_page)                              valid <= 1'b1;
      end
   end

   assign hit = valid && page_en && (page_sel == sel_q)
                && (((probe_addr ^ tag) & mask) == '0);

   assert_off_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !page_en |=> !valid);
   assert_close_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      close_page |=> !hit);
endmodule

// File: rtl/pgrd_sequencer.sv
module pgrd_sequencer
   import pgrd_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 6,
   parameter int BUS_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_page_en,
   input  logic [1:0]        cfg_page_sel,
   input  logic [CNT_W-1:0]  cfg_first_cyc,
   input  logic [CNT_W-1:0]  cfg_inpage_cyc,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   input  logic [DATA_W-1:0] mem_din
);
   localparam int LANE_LG = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;

   if (BUS_BYTES != 1 && BUS_BYTES != 2 && BUS_BYTES != 4) begin : g_bad_bus
      $error("pgrd_sequencer: BUS_BYTES must be 1, 2 or 4");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("pgrd_sequencer: ADDR_W must be at least 7");
   end

   pgrd_state_e       state, state_nx;
   logic [ADDR_W-1:0] addr_word;
   logic              accept, hit, in_hold_hit, expired;
   logic              open_page, close_page;
   logic [CNT_W-1:0]  load_val;

   if (LANE_LG == 0) begin : g_lane_none
      assign addr_word = req_addr;
   end else begin : g_lane_cut
      assign addr_word = {req_addr[ADDR_W-1:LANE_LG], {LANE_LG{1'b0}}};
   end

   assign req_ready   = (state == ST_IDLE) || (state == ST_HOLD);
   assign accept      = req_valid && req_ready;
   assign in_hold_hit = (state == ST_HOLD) && hit;
   assign open_page   = accept && !in_hold_hit;
   assign close_page  = (state == ST_HOLD) && !req_valid;
   assign load_val    = in_hold_hit ? cfg_inpage_cyc : cfg_first_cyc;

   pgrd_page_track #(
      .ADDR_W (ADDR_W),
      .SEL_W  (2),
      .MIN_LG (2)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .page_en    (cfg_page_en),
      .page_sel   (cfg_page_sel),
      .probe_addr (addr_word),
      .open_page  (open_page),
      .close_page (close_page),
      .hit        (hit)
   );

   pgrd_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (load_val),
      .run      (state == ST_ACC),
      .expired  (expired)
   );

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (accept) state_nx = ST_ACC;
         ST_HOLD: begin
            if (accept)          state_nx = in_hold_hit ? ST_ACC : ST_GAP;
            else                 state_nx = ST_IDLE;
         end
         ST_GAP:                 state_nx = ST_ACC;
         ST_ACC:  if (expired)   state_nx = ST_HOLD;
         default:                state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mem_addr  <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         state     <= state_nx;
         rsp_valid <= expired;
         if (accept)  mem_addr <= addr_word;
         if (expired) rsp_data <= mem_din;
      end
   end

   assign mem_cs_n = !((state == ST_HOLD) || (state == ST_ACC));
   assign mem_oe_n = (state != ST_ACC);

   assert_ready_low_in_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !req_ready);
   assert_rsp_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n));
   assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));
   assert_single_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs_n && !req_ready) |=> !mem_cs_n);
   assert_single_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   if (LANE_LG > 0) begin : g_lane_chk
      assert_lane_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
         mem_addr[LANE_LG-1:0] == '0);
   end
endmodule

// File: tb/pgrd_sequencer_test.sv
`timescale 1ns/1ps
module pgrd_sequencer_test;
   localparam int AW = 26;
   localparam int DW = 32;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_page_en = 1'b1;
   logic [1:0]    cfg_page_sel = 2'd0;
   logic [CW-1:0] cfg_first_cyc = 6'd5;
   logic [CW-1:0] cfg_inpage_cyc = 6'd1;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, rsp_valid, mem_cs_n, mem_oe_n;
   logic [DW-1:0] rsp_data, mem_din;
   logic [AW-1:0] mem_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
      return 32'h5A00_0000 ^ {6'd0, a};
   endfunction

   assign mem_din = mem_fn(mem_addr);

   pgrd_sequencer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .BUS_BYTES(4)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_page_en(cfg_page_en), .cfg_page_sel(cfg_page_sel),
      .cfg_first_cyc(cfg_first_cyc), .cfg_inpage_cyc(cfg_inpage_cyc),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_din(mem_din));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Issue a read at the current falling edge; return at the falling edge where rsp_valid is seen.
   task automatic do_read(input logic [AW-1:0] a, input int exp_lat, input int exp_gap,
                          input string req);
      int lat = 0;
      int gaps = 0;
      int rdy_hi = 0;
      check(req_ready == 1'b1, {req, " ready before request"}, req_ready, 1);
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid && lat < 300) begin
         if (mem_cs_n) gaps++;
         if (req_ready) rdy_hi++;
         @(negedge clk);
         lat++;
      end
      check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
      check(gaps == exp_gap, {req, " chip-select gap cycles"}, gaps, exp_gap);
      check(rdy_hi == 0, "R9 ready low during access", rdy_hi, 0);
      check(rsp_data == mem_fn({a[AW-1:2], 2'b00}), "R11 captured data", rsp_data,
            mem_fn({a[AW-1:2], 2'b00}));
      check(mem_addr == {a[AW-1:2], 2'b00}, "R10 low address bits", mem_addr,
            {a[AW-1:2], 2'b00});
   endtask

   task automatic go_idle();
      @(negedge clk);
      @(negedge clk);
      check(mem_cs_n == 1'b1, "R7 chip select released when idle", mem_cs_n, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(mem_cs_n && mem_oe_n && req_ready && !rsp_valid, "R1 state in reset",
            {mem_cs_n, mem_oe_n, req_ready, rsp_valid}, 4'b1110);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_cs_n && mem_oe_n && req_ready && !rsp_valid, "R1 state after reset",
            {mem_cs_n, mem_oe_n, req_ready, rsp_valid}, 4'b1110);
   endtask

   task automatic t_first_and_inpage();
      cfg_page_en = 1'b1; cfg_page_sel = 2'd0;
      do_read(26'h100, 6, 0, "R2 first access");
      do_read(26'h102, 2, 0, "R3 in-page access");
      do_read(26'h104, 7, 1, "R5 page miss");
      go_idle();
   endtask

   task automatic t_sizes();
      for (int s = 1; s < 4; s++) begin
         logic [AW-1:0] base;
         base = 26'h200 + 26'(s) * 26'h40;
         cfg_page_sel = 2'(s);
         @(negedge clk);
         do_read(base, 6, 0, "R4 open page");
         do_read(base + (26'd1 << (2 + s)) - 26'd4, 2, 0, "R4 last word of page hits");
         do_read(base + (26'd1 << (2 + s)), 7, 1, "R4 next page misses");
         go_idle();
      end
   endtask

   task automatic t_disabled();
      cfg_page_en = 1'b0; cfg_page_sel = 2'd3;
      @(negedge clk);
      do_read(26'h300, 6, 0, "R6 disabled first");
      do_read(26'h304, 7, 1, "R6 disabled same page");
      go_idle();
      cfg_page_en = 1'b1;
   endtask

   task automatic t_close();
      cfg_page_sel = 2'd3;
      @(negedge clk);
      do_read(26'h400, 6, 0, "R7 open page");
      @(negedge clk);
      check(rsp_valid == 1'b0, "R9 single response pulse", rsp_valid, 0);
      @(negedge clk);
      do_read(26'h404, 6, 0, "R7 page closed after release");
      go_idle();
   endtask

   task automatic t_size_change();
      cfg_page_sel = 2'd3;
      @(negedge clk);
      do_read(26'h500, 6, 0, "R8 open page");
      cfg_page_sel = 2'd2;
      do_read(26'h504, 7, 1, "R8 size change closes page");
      go_idle();
   endtask

   task automatic t_bounds();
      cfg_page_sel = 2'd3; cfg_first_cyc = 6'd63; cfg_inpage_cyc = 6'd0;
      @(negedge clk);
      do_read(26'h600, 64, 0, "R2 longest access");
      do_read(26'h608, 1, 0, "R3 shortest in-page access");
      go_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_first_and_inpage();
      t_sizes();
      t_disabled();
      t_close();
      t_size_change();
      t_bounds();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule